// File: doc/BRIEF.md
# Two-Wire Serial Host Frame Receiver

This block receives bytes that a peripheral sends to the host over a two-wire open-collector bus. The peripheral generates the bus clock. The block brings the clock and data lines into the system clock domain through synchronisers and a glitch filter. It detects each falling edge of the filtered bus clock and samples the data line at that edge. When eleven bits have arrived, it checks the framing and the parity of the frame. It then either presents the byte with a one-cycle valid pulse, or raises a one-cycle error pulse.

A frame starts with a 0 bit. Eight data bits follow, least significant bit first, then a parity bit and a closing 1 bit. The parity is odd: the nine bits made of the data and the parity bit must hold an odd number of ones. A frame can stall when the peripheral is cut off partway. A gap timer then discards the partial frame, so the next frame is received from its first bit. The block never drives the bus. Both lines idle high through pull-ups.

Top module: `ps2_host_rx`

## Requirements
- R1: While reset is asserted and directly after it, `rx_valid_o` and `rx_err_o` are 0 and `rx_byte_o` is 0x00.
- R2: A frame whose bit 0 is 0, whose bits 1..8 carry the data least significant bit first, whose bit 9 gives odd parity and whose bit 10 is 1 produces exactly one single-cycle `rx_valid_o` pulse, with `rx_byte_o` equal to the data.
- R3: A frame in which the data bits plus the parity bit hold an even number of ones produces one `rx_err_o` pulse and no `rx_valid_o`.
- R4: A frame whose first bit is 1 produces one `rx_err_o` pulse and no `rx_valid_o`.
- R5: A frame whose last bit is 0 produces one `rx_err_o` pulse and no `rx_valid_o`.
- R6: `rx_valid_o` and `rx_err_o` are never high together, and each is high for one system cycle only.
- R7: If no filtered falling edge arrives within GAP_US microseconds partway through a frame, the partial frame is dropped with no pulse. The next complete frame is received correctly.
- R8: A level on either line that lasts fewer than FILT_LEN system cycles after synchronisation is not accepted, so a short low glitch on the bus clock adds no bit.
- R9: `rx_byte_o` changes only together with `rx_valid_o`. After an error frame it still holds the last good byte.
- R10: While both lines stay high, neither output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_clk_i | input | 1 | Bus clock line, driven by the peripheral, pulled high when idle |
| line_dat_i | input | 1 | Bus data line, pulled high when idle |
| rx_byte_o | output | 8 | Last byte received without error |
| rx_valid_o | output | 1 | One-cycle pulse when a good byte is presented |
| rx_err_o | output | 1 | One-cycle pulse on a bad start, stop or parity bit |

## Verification
The frame decoder is driven with a set of bytes that includes 0x00, 0xFF, alternating patterns and single-bit values. This set exposes bit-order and shift-direction faults. Frames with only a flipped parity bit, a start bit of 1 or a stop bit of 0 are used to tell the three error sources apart. A good byte follows each such frame, to show that the held output is not disturbed. A frame stalled after four bits, followed by a complete frame, separates a working gap timer from a misaligned bit counter. A short low glitch just before a frame shows whether the edge filter counts spurious edges.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;
  localparam int FRAME_BITS = 11;
  localparam int IDX_W      = 4;

  // A frame is accepted when the first bit is 0, the last bit is 1 and
  // the nine data+parity bits contain an odd number of ones.
  function automatic logic frame_good(input logic [FRAME_BITS-1:0] f);
    return (f[0] == 1'b0) && (f[FRAME_BITS-1] == 1'b1) && (^f[9:1] == 1'b1);
  endfunction

  function automatic logic [7:0] frame_payload(input logic [FRAME_BITS-1:0] f);
    return f[8:1];
  endfunction
endpackage

// File: rtl/ps2rx_line_filt.sv
module ps2rx_line_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   lvl_q;
  logic                   s_lvl;

  assign s_lvl   = sync_q[SYNC_STAGES-1];
  assign level_o = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  // A new level is taken only after FILT_LEN consecutive differing samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else if (s_lvl == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT_LEN - 1)) begin
      lvl_q <= s_lvl;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ps2rx_gap_timer.sv
module ps2rx_gap_timer #(
  parameter int LIMIT = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt_q;
  logic          hit;

  assign hit = run_i && !kick_i && (cnt_q == TW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= hit;
      if (!run_i || kick_i || hit) cnt_q <= '0;
      else                         cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ps2rx_frame_asm.sv
module ps2rx_frame_asm
  import ps2rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_evt_i,
  input  logic             bit_i,
  input  logic             abort_i,
  output logic [7:0]       byte_o,
  output logic             valid_o,
  output logic             err_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [FRAME_BITS-1:0] sh_q;
  logic [FRAME_BITS-1:0] sh_n;
  logic [IDX_W-1:0]      idx_q;
  logic                  last_bit;

  assign sh_n     = {bit_i, sh_q[FRAME_BITS-1:1]};
  assign last_bit = (idx_q == IDX_W'(FRAME_BITS - 1));
  assign idx_o    = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '1;
      idx_q   <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      if (abort_i) begin
        idx_q <= '0;
      end else if (bit_evt_i) begin
        sh_q <= sh_n;
        if (last_bit) begin
          idx_q <= '0;
          if (frame_good(sh_n)) begin
            valid_o <= 1'b1;
            byte_o  <= frame_payload(sh_n);
          end else begin
            err_o <= 1'b1;
          end
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ps2_host_rx.sv
module ps2_host_rx
  import ps2rx_pkg::*;
#(
  parameter int CLKS_PER_US = 50,
  parameter int GAP_US      = 100,
  parameter int FILT_LEN    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_clk_i,
  input  logic       line_dat_i,
  output logic [7:0] rx_byte_o,
  output logic       rx_valid_o,
  output logic       rx_err_o
);
  localparam int GAP_CYC = CLKS_PER_US * GAP_US;
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] clean_lines;
  logic               clk_prev_q;
  logic               bit_evt;
  logic               gap_expire;
  logic [IDX_W-1:0]   bit_idx;

  assign raw_lines = {line_dat_i, line_clk_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    ps2rx_line_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_i(raw_lines[g]), .level_o(clean_lines[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev_q <= 1'b1;
    else        clk_prev_q <= clean_lines[0];
  end

  assign bit_evt = clk_prev_q && !clean_lines[0];

  ps2rx_gap_timer #(.LIMIT(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .run_i(bit_idx != '0),
    .kick_i(bit_evt), .expire_o(gap_expire)
  );

  ps2rx_frame_asm u_asm (
    .clk(clk), .rst_n(rst_n), .bit_evt_i(bit_evt), .bit_i(clean_lines[1]),
    .abort_i(gap_expire), .byte_o(rx_byte_o), .valid_o(rx_valid_o),
    .err_o(rx_err_o), .idx_o(bit_idx)
  );
endmodule

// File: rtl/ps2rx_chk.sv
module ps2rx_chk
  import ps2rx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       rx_byte_o,
  input logic             rx_valid_o,
  input logic             rx_err_o,
  input logic             bit_evt,
  input logic             gap_expire,
  input logic [IDX_W-1:0] bit_idx
);
  AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid_o && rx_err_o)); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o); // R6
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_o |=> !rx_err_o); // R6
  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_o |-> $stable(rx_byte_o)); // R9
  AST_OUT_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o || rx_err_o) |-> $past(bit_evt)); // R2
  AST_GAP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    gap_expire |=> (bit_idx == '0 && !rx_valid_o && !rx_err_o)); // R7
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx < IDX_W'(FRAME_BITS)); // R2
endmodule

bind ps2_host_rx ps2rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o),
  .rx_err_o(rx_err_o), .bit_evt(bit_evt), .gap_expire(gap_expire), .bit_idx(bit_idx)
);

// File: tb/ps2_host_rx_tb.sv
module ps2_host_rx_tb;
  localparam int CPU  = 2;   // system clocks per microsecond in this bench
  localparam int HALF = 80;  // 40 us half period of the bus clock
  localparam int NV   = 9;
  // Vector fields: [10] bad stop, [9] bad start, [8] flipped parity, [7:0] data
  localparam logic [10:0] VEC [NV] = '{
    11'h015, 11'h000, 11'h0FF, 11'h0A5, 11'h080,
    11'h13C, 11'h201, 11'h47E, 11'h05A
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_clk = 1'b1;
  logic line_dat = 1'b1;
  logic [7:0] rx_byte;
  logic rx_valid, rx_err;

  int n_tests = 0, n_fail = 0;
  int n_valid = 0, n_err = 0, n_both = 0, n_long = 0;
  logic prev_pulse = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  ps2_host_rx #(.CLKS_PER_US(CPU), .GAP_US(100), .FILT_LEN(4), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_clk_i(line_clk), .line_dat_i(line_dat),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .rx_err_o(rx_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) n_valid++;
      if (rx_err) n_err++;
      if (rx_valid && rx_err) n_both++;
      if ((rx_valid || rx_err) && prev_pulse) n_long++;
      prev_pulse <= rx_valid || rx_err;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [10:0] f, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      line_dat = f[i];
      wait_cyc(HALF);
      line_clk = 1'b0;
      wait_cyc(HALF);
      line_clk = 1'b1;
    end
    line_dat = 1'b1;
  endtask

  function automatic logic [10:0] make_frame(input logic [10:0] v);
    logic par;
    par = ~(^v[7:0]) ^ v[8];
    return {~v[10], par, v[7:0], v[9]};
  endfunction

  task automatic frame_case(input logic [10:0] v, inout logic [7:0] held);
    int v0, e0;
    bit bad;
    v0 = n_valid; e0 = n_err;
    bad = |v[10:8];
    send_bits(make_frame(v), 11);
    wait_cyc(40);
    if (!bad) begin
      chk(n_valid == v0 + 1 && n_err == e0, "R2 valid count", n_valid - v0, 1);
      chk(rx_byte == v[7:0], "R2 byte", rx_byte, v[7:0]);
      held = v[7:0];
    end else begin
      if (v[8]) chk(n_err == e0 + 1 && n_valid == v0, "R3 parity err", n_err - e0, 1);
      if (v[9]) chk(n_err == e0 + 1 && n_valid == v0, "R4 start err", n_err - e0, 1);
      if (v[10]) chk(n_err == e0 + 1 && n_valid == v0, "R5 stop err", n_err - e0, 1);
      chk(rx_byte == held, "R9 byte held", rx_byte, held);
    end
    wait_cyc(100);
  endtask

  initial begin
    logic [7:0] held;
    int v0, e0;
    held = 8'h00;
    wait_cyc(5);
    chk(rx_valid == 0 && rx_err == 0 && rx_byte == 0, "R1 in reset", {rx_valid, rx_err, rx_byte}, 0);
    rst_n = 1'b1;
    wait_cyc(2);
    chk(rx_valid == 0 && rx_err == 0 && rx_byte == 0, "R1 after reset", {rx_valid, rx_err, rx_byte}, 0);

    // R10: idle bus
    wait_cyc(500);
    chk(n_valid == 0 && n_err == 0, "R10 idle quiet", n_valid + n_err, 0);

    for (int i = 0; i < NV; i++) frame_case(VEC[i], held);

    // R7: stall after four bits, then a complete frame
    v0 = n_valid; e0 = n_err;
    send_bits(make_frame(11'h0C3), 4);
    wait_cyc(150 * CPU);
    chk(n_valid == v0 && n_err == e0, "R7 partial dropped", n_valid + n_err - v0 - e0, 0);
    send_bits(make_frame(11'h0C3), 11);
    wait_cyc(40);
    chk(n_valid == v0 + 1 && n_err == e0 && rx_byte == 8'hC3, "R7 resync", rx_byte, 8'hC3);
    held = 8'hC3;
    wait_cyc(100);

    // R8: short low glitch on the bus clock just before a frame
    v0 = n_valid; e0 = n_err;
    line_clk = 1'b0; wait_cyc(2); line_clk = 1'b1;
    wait_cyc(20 * CPU);
    send_bits(make_frame(11'h069), 11);
    wait_cyc(40);
    chk(n_valid == v0 + 1 && n_err == e0 && rx_byte == 8'h69, "R8 glitch ignored", rx_byte, 8'h69);

    chk(n_both == 0 && n_long == 0, "R6 exclusive single pulses", n_both + n_long, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule